// File: doc/BRIEF.md
# Scanline Pixel Buffers

This block holds sprite pixels for video scanlines in four buffers grouped as two pairs. In each pair, one buffer is in the render role and collects sprite pixels for the coming line. The other buffer is in the display role and is read out for the current line. A line strobe exchanges the two roles in both pairs. Every stored word carries two neighbouring pixels, lane A and lane B. Each pixel is a 4-bit colour code plus an 8-bit palette group that comes with the write.

During readout the block takes the two display buffers, one from each pair, and a text-layer pixel arriving on its own stream. From these it forms one 12-bit palette address per lane. A text pixel wins when it is non-zero. Otherwise the first pair's pixel is used, then the second pair's. The order select input decides which pair counts as first. A display word that has been consumed is cleared to transparent, so that buffer starts the next line empty.

Writes arrive on a valid/ready stream. Text pixels arrive on a second stream, and that stream is joined without storage to the palette output stream. Readiness passes straight back from the output to the text input. The line strobe takes priority over both streams: in its cycle every ready and the output valid drop low, so nothing transfers. All other pins are plain control levels.

Top module: `line_pixel_buffers`

## Requirements
- R1: After reset the line phase is 0, every buffer address counter is 0 and every stored pixel is transparent. With a zero text pixel both palette outputs are 0. wr_ready is 1.
- R2: In pair p (buffers 2p and 2p+1), the render-role buffer is 2p+(mode_sel[p] XOR phase) and the other buffer of the pair is in the display role. Each cycle with line_swap high toggles the phase.
- R3: On a write transfer (wr_valid and wr_ready), each render-role buffer whose buf_we bit is 1 stores the lane A and lane B pixels at word counter/2. A lane whose code is 0 leaves that stored pixel unchanged.
- R4: Each counter is a pixel address that holds even values from 0 to 318. It steps by 2 on a transfer of its own role's stream when its buf_ce bit is 1, and it wraps from 318 to 0. With buf_ce low it holds.
- R5: reload[p] loads both counters of pair p with start_addr. Bit 0 is forced to 0, and a value of 320 or more loads 0. Reload overrides a step in the same cycle, and any store or clear in that cycle uses the address from before the reload.
- R6: On an output transfer (out_valid and out_ready), each display-role buffer whose buf_ce bit is 1 clears its current word to transparent and steps.
- R7: Per lane, the output is {fix_grp, text code} if the text code is non-zero. Otherwise it is the first pair's display pixel {group, code} if that code is non-zero, then the second pair's, and 0 if all are transparent. order_sel=0 makes pair 0 first and order_sel=1 makes pair 1 first.
- R8: out_valid = fix_valid AND NOT line_swap, fix_ready = out_ready AND NOT line_swap, and wr_ready = NOT line_swap. No write, step or clear happens in a swap cycle.
- R9: A render-role buffer whose buf_we bit is 0 keeps its content on a write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| wr_code_a | input | 4 | Lane A sprite code |
| wr_code_b | input | 4 | Lane B sprite code |
| wr_grp | input | 8 | Palette group for both lanes |
| buf_we | input | 4 | Per-buffer write enable |
| buf_ce | input | 4 | Per-buffer counter step enable |
| mode_sel | input | 2 | Per-pair role select |
| reload | input | 2 | Per-pair counter reload |
| start_addr | input | 9 | Reload start pixel address |
| order_sel | input | 1 | Pair priority order |
| line_swap | input | 1 | Line strobe that exchanges roles |
| fix_valid | input | 1 | Text pixel stream valid |
| fix_ready | output | 1 | Text pixel stream ready |
| fix_code_a | input | 4 | Lane A text code |
| fix_code_b | input | 4 | Lane B text code |
| fix_grp | input | 8 | Text palette group |
| out_valid | output | 1 | Palette stream valid |
| out_ready | input | 1 | Palette stream ready |
| out_pal_a | output | 12 | Lane A palette address |
| out_pal_b | output | 12 | Lane B palette address |

## Verification
A counter reload can land in the same cycle as a write that also steps the same buffer. The bench provokes this by issuing a write with buf_ce set while reload and an odd start address are applied. Afterwards it swaps the roles and reads the buffer back. It judges the result by two facts. The data must be found at the pre-reload word. The next write must land at the reloaded word, not one word further on. The line strobe is also raised together with pending writes and reads, and the bench confirms that no data appears in the buffers that were targeted.

// File: rtl/lpb_pkg.sv
package lpb_pkg;
  parameter int CODE_W = 4;
  parameter int GRP_W  = 8;
  parameter int PAL_W  = CODE_W + GRP_W;

  typedef struct packed {
    logic [GRP_W-1:0]  grp;
    logic [CODE_W-1:0] code;
  } pix_t;
endpackage

// File: rtl/lpb_counter.sv
module lpb_counter #(
  parameter int WORDS  = 160,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              reload,
  input  logic [ADDR_W-1:0] start,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(2 * WORDS);
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(2 * WORDS - 2);
  localparam logic [ADDR_W-1:0] TWO   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] EVEN  = ~ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (reload) begin
      addr <= (start >= LIMIT) ? '0 : (start & EVEN);
    end else if (step) begin
      addr <= (addr >= LAST) ? '0 : addr + TWO;
    end
  end
endmodule

// File: rtl/lpb_bank.sv
module lpb_bank
  import lpb_pkg::*;
#(
  parameter int WORDS  = 160,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              reload,
  input  logic [ADDR_W-1:0] start,
  input  logic              wr,
  input  logic              clr,
  input  pix_t [1:0]        wr_px,
  output pix_t [1:0]        rd_px,
  output logic [ADDR_W-1:0] addr
);
  localparam int IDX_W = ADDR_W - 1;

  pix_t [1:0]       mem [WORDS];
  logic [IDX_W-1:0] widx;

  lpb_counter #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .step(step), .reload(reload),
    .start(start), .addr(addr)
  );

  assign widx  = addr[ADDR_W-1:1];
  assign rd_px = mem[widx];

  // A clear wipes the whole word; a write touches only the non-zero lanes.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (clr) begin
      mem[widx] <= '0;
    end else if (wr) begin
      for (int l = 0; l < 2; l++)
        if (wr_px[l].code != '0) mem[widx][l] <= wr_px[l];
    end
  end
endmodule

// File: rtl/lpb_mix.sv
module lpb_mix
  import lpb_pkg::*;
(
  input  pix_t [1:0]             fix_px,
  input  pix_t [1:0]             first_px,
  input  pix_t [1:0]             second_px,
  output logic [1:0][PAL_W-1:0]  pal
);
  for (genvar l = 0; l < 2; l++) begin : g_lane
    always_comb begin
      if (fix_px[l].code != '0)         pal[l] = fix_px[l];
      else if (first_px[l].code != '0)  pal[l] = first_px[l];
      else if (second_px[l].code != '0) pal[l] = second_px[l];
      else                              pal[l] = '0;
    end
  end
endmodule

// File: rtl/line_pixel_buffers.sv
module line_pixel_buffers
  import lpb_pkg::*;
#(
  parameter int WORDS  = 160,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CODE_W-1:0] wr_code_a,
  input  logic [CODE_W-1:0] wr_code_b,
  input  logic [GRP_W-1:0]  wr_grp,
  input  logic [3:0]        buf_we,
  input  logic [3:0]        buf_ce,
  input  logic [1:0]        mode_sel,
  input  logic [1:0]        reload,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              order_sel,
  input  logic              line_swap,
  input  logic              fix_valid,
  output logic              fix_ready,
  input  logic [CODE_W-1:0] fix_code_a,
  input  logic [CODE_W-1:0] fix_code_b,
  input  logic [GRP_W-1:0]  fix_grp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PAL_W-1:0]  out_pal_a,
  output logic [PAL_W-1:0]  out_pal_b
);
  localparam int NPAIR = 2;
  localparam int NBUF  = 2 * NPAIR;

  logic                         phase_q;
  logic [NPAIR-1:0]             rsel;
  logic                         fire_w, fire_r;
  logic [NBUF-1:0]              step_all;
  logic [NBUF-1:0][ADDR_W-1:0]  addr_all;
  pix_t [1:0]                   wr_px, fix_px, first_px, second_px;
  pix_t [1:0]                   rd_px   [NBUF];
  pix_t [1:0]                   disp_px [NPAIR];
  logic [1:0][PAL_W-1:0]        pal;

  // The line strobe outranks both streams.
  assign wr_ready  = !line_swap;
  assign out_valid = fix_valid && !line_swap;
  assign fix_ready = out_ready && !line_swap;
  assign fire_w    = wr_valid && wr_ready;
  assign fire_r    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)         phase_q <= 1'b0;
    else if (line_swap) phase_q <= !phase_q;
  end

  assign rsel = mode_sel ^ {NPAIR{phase_q}};

  assign wr_px[0]  = '{grp: wr_grp, code: wr_code_a};
  assign wr_px[1]  = '{grp: wr_grp, code: wr_code_b};
  assign fix_px[0] = '{grp: fix_grp, code: fix_code_a};
  assign fix_px[1] = '{grp: fix_grp, code: fix_code_b};

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    localparam int   P = b / 2;
    localparam logic H = 1'(b % 2);
    logic is_r, wr_b, clr_b;
    assign is_r        = (rsel[P] == H);
    assign step_all[b] = buf_ce[b] && (is_r ? fire_w : fire_r);
    assign wr_b        = is_r && fire_w && buf_we[b];
    assign clr_b       = !is_r && fire_r && buf_ce[b];

    lpb_bank #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .step(step_all[b]), .reload(reload[P]),
      .start(start_addr), .wr(wr_b), .clr(clr_b), .wr_px(wr_px),
      .rd_px(rd_px[b]), .addr(addr_all[b])
    );
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign disp_px[p] = rsel[p] ? rd_px[2*p] : rd_px[2*p+1];
  end

  assign first_px  = order_sel ? disp_px[1] : disp_px[0];
  assign second_px = order_sel ? disp_px[0] : disp_px[1];

  lpb_mix u_mix (
    .fix_px(fix_px), .first_px(first_px), .second_px(second_px), .pal(pal)
  );

  assign out_pal_a = pal[0];
  assign out_pal_b = pal[1];
endmodule

// File: rtl/lpb_chk.sv
module lpb_chk #(
  parameter int NBUF   = 4,
  parameter int ADDR_W = 9,
  parameter int WORDS  = 160
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        line_swap,
  input logic                        out_valid,
  input logic                        wr_ready,
  input logic                        fix_ready,
  input logic                        phase,
  input logic [NBUF/2-1:0]           reload,
  input logic [ADDR_W-1:0]           start,
  input logic [NBUF-1:0][ADDR_W-1:0] addr_all,
  input logic [NBUF-1:0]             step_all
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(2 * WORDS);
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(2 * WORDS - 2);

  // R8
  swap_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_swap |-> (!out_valid && !wr_ready && !fix_ready));

  // R2
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_swap |=> (phase != $past(phase)));

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_swap |=> $stable(phase));

  for (genvar b = 0; b < NBUF; b++) begin : g_b
    // R4
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_all[b] < LIMIT) && !addr_all[b][0]);

    // R4
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_all[b] && !reload[b/2] && addr_all[b] == LAST) |=> (addr_all[b] == '0));

    // R5
    reload_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reload[b/2] && start >= LIMIT) |=> (addr_all[b] == '0));
  end
endmodule

bind line_pixel_buffers lpb_chk #(.NBUF(NBUF), .ADDR_W(ADDR_W), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_swap(line_swap), .out_valid(out_valid),
  .wr_ready(wr_ready), .fix_ready(fix_ready), .phase(phase_q),
  .reload(reload), .start(start_addr), .addr_all(addr_all), .step_all(step_all)
);

// File: tb/sim_line_pixel_buffers.sv
module sim_line_pixel_buffers;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, wr_ready;
  logic [3:0] wr_code_a = 0, wr_code_b = 0;
  logic [7:0] wr_grp = 0;
  logic [3:0] buf_we = 0, buf_ce = 0;
  logic [1:0] mode_sel = 0, reload = 0;
  logic [8:0] start_addr = 0;
  logic order_sel = 0, line_swap = 0;
  logic fix_valid = 1, fix_ready;
  logic [3:0] fix_code_a = 0, fix_code_b = 0;
  logic [7:0] fix_grp = 0;
  logic out_valid, out_ready = 0;
  logic [11:0] out_pal_a, out_pal_b;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  line_pixel_buffers u0 (.*);

  // {fix_a, fix_b, fix_grp, order, exp_a, exp_b}
  localparam logic [40:0] TBL [5] = '{
    {4'h0, 4'h0, 8'h55, 1'b0, 12'h113, 12'h115},
    {4'h0, 4'h0, 8'h55, 1'b1, 12'h227, 12'h115},
    {4'h2, 4'h0, 8'h55, 1'b0, 12'h552, 12'h115},
    {4'h0, 4'h6, 8'h55, 1'b1, 12'h227, 12'h556},
    {4'hF, 4'hF, 8'hAB, 1'b1, 12'hABF, 12'hABF}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [11:0] ea, input logic [11:0] eb);
    #1;
    chk({tag, " lane A"}, out_pal_a, ea);
    chk({tag, " lane B"}, out_pal_b, eb);
  endtask

  task automatic put(input logic [3:0] we, input logic [3:0] ce, input logic [3:0] a,
                     input logic [3:0] b, input logic [7:0] g,
                     input logic [1:0] rl, input logic [8:0] st);
    buf_we = we; buf_ce = ce; wr_code_a = a; wr_code_b = b; wr_grp = g;
    reload = rl; start_addr = st; wr_valid = 1;
    tick();
    wr_valid = 0; buf_we = 0; buf_ce = 0; reload = 0;
  endtask

  task automatic swap();
    line_swap = 1; tick(); line_swap = 0;
  endtask

  task automatic rld(input logic [1:0] rl, input logic [8:0] st);
    reload = rl; start_addr = st; tick(); reload = 0;
  endtask

  task automatic read_step(input logic [3:0] ce);
    buf_ce = ce; out_ready = 1; tick(); buf_ce = 0; out_ready = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    // R1 reset state
    #1;
    chk("R1 wr_ready", {11'd0, wr_ready}, 12'd1);
    chk("R1 out_valid", {11'd0, out_valid}, 12'd1);
    chk_out("R1 empty", 12'h000, 12'h000);

    // Fill in phase 0: render buffers 0 and 2 (R3)
    put(4'b0001, 4'b0001, 4'h3, 4'h5, 8'h11, 2'b00, 9'd0);
    put(4'b0100, 4'b0100, 4'h7, 4'h0, 8'h22, 2'b00, 9'd0);
    put(4'b0001, 4'b0000, 4'h9, 4'h0, 8'h33, 2'b00, 9'd0);
    put(4'b0001, 4'b0001, 4'h0, 4'h4, 8'h44, 2'b00, 9'd0);
    swap();
    rld(2'b11, 9'd0);
    chk_out("R2 swapped roles", 12'h113, 12'h115);

    // R7 merge table
    for (int i = 0; i < 5; i++) begin
      fix_code_a = TBL[i][40:37]; fix_code_b = TBL[i][36:33];
      fix_grp = TBL[i][32:25]; order_sel = TBL[i][24];
      chk_out("R7 merge", TBL[i][23:12], TBL[i][11:0]);
      tick();
    end
    fix_code_a = 0; fix_code_b = 0; fix_grp = 0; order_sel = 0;

    // R6 clear after read, R4 step, R3 transparent lanes kept
    read_step(4'b0001);
    chk_out("R4 step / R3 lanes", 12'h339, 12'h444);
    rld(2'b01, 9'd0);
    chk_out("R6 cleared word", 12'h227, 12'h000);

    // R8 back-pressure: ce set but out_ready low, no step
    buf_ce = 4'b0001; out_ready = 0;
    #1 chk("R8 fix_ready", {11'd0, fix_ready}, 12'd0);
    tick(); buf_ce = 0;
    chk_out("R8 no step when stalled", 12'h227, 12'h000);

    // R8 swap blocks a pending write and read
    line_swap = 1; wr_valid = 1; buf_we = 4'b1111; buf_ce = 4'b1111;
    wr_code_a = 4'h1; wr_code_b = 4'h1; wr_grp = 8'h99; out_ready = 1;
    #1;
    chk("R8 out_valid in swap", {11'd0, out_valid}, 12'd0);
    chk("R8 wr_ready in swap", {11'd0, wr_ready}, 12'd0);
    chk("R8 fix_ready in swap", {11'd0, fix_ready}, 12'd0);
    tick();
    line_swap = 0; wr_valid = 0; buf_we = 0; buf_ce = 0; out_ready = 0;
    chk_out("R8 write blocked", 12'h000, 12'h000);

    // R5 reload in the same cycle as a stepping write (phase 0: render 0,2)
    put(4'b0001, 4'b0001, 4'h6, 4'h6, 8'h66, 2'b01, 9'd10);
    put(4'b0001, 4'b0001, 4'h8, 4'h8, 8'h77, 2'b00, 9'd0);
    swap();
    rld(2'b11, 9'd0);
    chk_out("R5 old address used", 12'h666, 12'h666);
    rld(2'b01, 9'd11);
    chk_out("R5 reload beats step", 12'h778, 12'h778);
    rld(2'b01, 9'd400);
    chk_out("R5 clamp", 12'h666, 12'h666);

    // R4 wrap from 318 to 0
    rld(2'b01, 9'd318);
    chk_out("R4 last word", 12'h227, 12'h000);
    read_step(4'b0001);
    chk_out("R4 wrap", 12'h666, 12'h666);

    // R9 write enable low (phase 1: render 1,3)
    put(4'b0000, 4'b0010, 4'h1, 4'h1, 8'h99, 2'b00, 9'd0);
    swap();
    rld(2'b11, 9'd0);
    chk_out("R9 we low ignored", 12'h000, 12'h000);

    // R2 mode select flips pair 0 roles (phase 0, mode 01: display buffer 0)
    mode_sel = 2'b01;
    chk_out("R2 mode select", 12'h666, 12'h666);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule